// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial frames from a single line that is sampled by the system clock. The frame format is chosen at run time through static inputs. The data length can be 5 to 9 bits. Parity has six modes. There can be zero, one or two stop bits. The bit order is selectable, and so is the line polarity. The point within each bit time where the line is sampled is also programmable, as a percentage of the bit time, and the clocks-per-bit divisor is an input.

When a frame has been received, the block emits a one-cycle `frame_done` pulse. In the same cycle it presents the right-aligned data word together with a start-error, parity-error and stop-error flag and an overall validity flag. The result port has no back-pressure. The consumer must take the word in the cycle in which `frame_done` is high, because nothing is held or retried. The configuration inputs may change only while no frame is in progress.

Top module: `uart_frame_rx`

## Requirements
- R1: `data_bits` selects 5 to 9 data bits. A value below 5 acts as 5 and a value above 9 acts as 9. `frame_data` is right-aligned, and every bit above the selected length reads 0.
- R2: When `msb_first` is 0, the first data bit received lands in `frame_data[0]`. When `msb_first` is 1, the first data bit received lands in `frame_data[n-1]`, where n is the selected length.
- R3: `parity_mode` encoding is 0 none, 1 odd, 2 even, 3 forced zero, 4 forced one, 5 ignore, and 6 or 7 act as none. Odd passes when the data ones plus the parity bit total an odd number, and even passes when that total is even. Forced zero needs a parity bit of 0 and forced one needs 1. Ignore always passes. A failing check sets `parity_err`.
- R4: Count the cycles after the cycle in which the synchronised line edge is seen. Bit n (start bit = 0) is sampled at cycle n*C + floor((C-1)*p/100), where C is `clks_per_bit` and p is `sample_pct`. A p outside 1..99 acts as 50.
- R5: While idle, a falling edge of the decoded line begins a frame. If the start bit samples as 1, the block pulses `frame_done` with `start_err`=1, `frame_valid`=0 and `frame_data`=0, and it returns to waiting for an edge.
- R6: `stop_bits` gives 0, 1 or 2 stop bits, and 3 acts as 2. If any stop bit samples as 0, `stop_err` is set. The frame still completes and is reported.
- R7: With parity none, no parity bit time exists. With zero stop bits, the frame ends after the last data or parity bit.
- R8: When `invert` is 1, the line is complemented before any decoding, so idle is low and the start edge is rising.
- R9: The line passes through a two-flop synchroniser. After reset every output is 0.
- R10: `frame_done` is a single-cycle pulse at the end of the last bit time of the frame. It carries the data and flags, and `frame_valid` is 1 exactly when no error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, asynchronous |
| invert | input | 1 | Complement the line before decoding |
| msb_first | input | 1 | Bit order: 1 means the first data bit is the MSB |
| data_bits | input | 4 | Data length, 5..9 |
| parity_mode | input | 3 | Parity mode encoding (see R3) |
| stop_bits | input | 2 | Stop bit count, 0..2 |
| sample_pct | input | 7 | Sample position in percent of a bit time |
| clks_per_bit | input | 16 | Clock cycles per bit time |
| frame_done | output | 1 | One-cycle result strobe |
| frame_data | output | 9 | Received data word |
| start_err | output | 1 | Start bit sampled high |
| parity_err | output | 1 | Parity check failed |
| stop_err | output | 1 | A stop bit sampled low |
| frame_valid | output | 1 | Frame has no error |

## Verification
The assertions take three things for granted about the inputs. The configuration is held steady for the whole of a frame. `clks_per_bit` is at least 4, so the sample tick of a bit always falls strictly before the end of that bit. The line stays at its idle level long enough to produce a clean start edge. The stimulus follows these rules. It changes settings only in idle gaps of eight cycles or more between frames, and it changes `invert` and the idle level of the line in the same cycle, so no false edge appears. It uses bit times of 16 and 20 clocks. In the window tests, each data bit holds its true value for only one cycle of the bit time, so a sample point that is off by a single cycle produces a wrong word.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE   = 3'd0,
    PAR_ODD    = 3'd1,
    PAR_EVEN   = 3'd2,
    PAR_ZERO   = 3'd3,
    PAR_ONE    = 3'd4,
    PAR_IGNORE = 3'd5
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  // Pass/fail of the parity bit given the reduction XOR of the data word.
  function automatic logic parity_pass(par_mode_e mode, logic data_odd, logic pbit);
    case (mode)
      PAR_ODD:  return (data_odd ^ pbit) == 1'b1;
      PAR_EVEN: return (data_odd ^ pbit) == 1'b0;
      PAR_ZERO: return pbit == 1'b0;
      PAR_ONE:  return pbit == 1'b1;
      default:  return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  output logic line
);
  logic [STAGES-1:0] sr;

  // Polarity is corrected ahead of the flops so idle always resets to 1.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '1;
    else        sr <= {sr[STAGES-2:0], raw ^ invert};
  end

  assign line = sr[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
  parameter int CPB_W = 16,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CPB_W-1:0] cpb,
  input  logic [PCT_W-1:0] pct,
  output logic             sample_tick,
  output logic             bit_end
);
  localparam int PROD_W = CPB_W + PCT_W;

  logic [PCT_W-1:0]  pct_eff;
  logic [PROD_W-1:0] prod;
  logic [CPB_W-1:0]  offset;
  logic [CPB_W-1:0]  ph;

  always_comb begin
    pct_eff = (pct >= PCT_W'(1) && pct <= PCT_W'(99)) ? pct : PCT_W'(50);
    prod    = PROD_W'(cpb - 1'b1) * PROD_W'(pct_eff);
    offset  = CPB_W'(prod / PROD_W'(100));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ph <= '0;
    else if (!run)               ph <= '0;
    else if (ph == cpb - 1'b1)   ph <= '0;
    else                         ph <= ph + 1'b1;
  end

  assign sample_tick = run && (ph == offset);
  assign bit_end     = run && (ph == cpb - 1'b1);

  // R4: the bit phase never leaves the programmed bit time
  p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ph < cpb);
  // R4: sampling and the bit boundary never coincide
  p_tick_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> !sample_tick);
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_frame_rx_pkg::*;
#(
  parameter int DATA_MAX = 9,
  parameter int CNT_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line,
  input  logic                sample_tick,
  input  logic                bit_end,
  input  logic [CNT_W-1:0]    nbits,
  input  par_mode_e           pmode,
  input  logic [1:0]          nstop,
  input  logic                msb_first,
  output logic                run,
  output logic                frame_done,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                start_err,
  output logic                parity_err,
  output logic                stop_err,
  output logic                frame_valid
);
  rx_state_e           st;
  logic                prev;
  logic [DATA_MAX-1:0] bits_q;
  logic                pbit_q;
  logic                stop_bad_q;
  logic [CNT_W-1:0]    idx;
  logic [DATA_MAX-1:0] word;
  logic                has_par, par_ok, finish, fall;

  assign run  = (st != ST_IDLE);
  assign fall = prev && !line;

  always_comb begin
    word = '0;
    for (int i = 0; i < DATA_MAX; i++) begin
      if (i < int'(nbits)) begin
        if (msb_first) word[i] = bits_q[int'(nbits) - 1 - i];
        else           word[i] = bits_q[i];
      end
    end
    has_par = (pmode != PAR_NONE);
    par_ok  = parity_pass(pmode, ^word, pbit_q);
    finish  = bit_end && (
                (st == ST_DATA && idx == nbits - 1'b1 && !has_par && nstop == 2'd0) ||
                (st == ST_PARITY && nstop == 2'd0) ||
                (st == ST_STOP && idx == CNT_W'(nstop) - 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  prev <= 1'b1;  bits_q <= '0;  pbit_q <= 1'b0;
      stop_bad_q <= 1'b0;  idx <= '0;
      frame_done <= 1'b0;  frame_data <= '0;  start_err <= 1'b0;
      parity_err <= 1'b0;  stop_err <= 1'b0;  frame_valid <= 1'b0;
    end else begin
      prev       <= line;
      frame_done <= 1'b0;
      case (st)
        ST_IDLE: if (fall) begin
          st <= ST_START;  bits_q <= '0;  pbit_q <= 1'b0;  stop_bad_q <= 1'b0;
        end
        ST_START: begin
          if (sample_tick && line) begin
            st <= ST_IDLE;  frame_done <= 1'b1;  frame_data <= '0;
            start_err <= 1'b1;  parity_err <= 1'b0;  stop_err <= 1'b0;
            frame_valid <= 1'b0;
          end else if (bit_end) begin
            st <= ST_DATA;  idx <= '0;
          end
        end
        ST_DATA: begin
          if (sample_tick) bits_q[idx] <= line;
          if (bit_end) begin
            if (idx == nbits - 1'b1) begin
              idx <= '0;
              if (has_par)            st <= ST_PARITY;
              else if (nstop != 2'd0) st <= ST_STOP;
              else                    st <= ST_IDLE;
            end else idx <= idx + 1'b1;
          end
        end
        ST_PARITY: begin
          if (sample_tick) pbit_q <= line;
          if (bit_end) begin
            idx <= '0;
            st  <= (nstop != 2'd0) ? ST_STOP : ST_IDLE;
          end
        end
        ST_STOP: begin
          if (sample_tick && !line) stop_bad_q <= 1'b1;
          if (bit_end) begin
            if (idx == CNT_W'(nstop) - 1'b1) st <= ST_IDLE;
            else                              idx <= idx + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
      if (finish) begin
        frame_done  <= 1'b1;
        frame_data  <= word;
        start_err   <= 1'b0;
        parity_err  <= has_par && !par_ok;
        stop_err    <= stop_bad_q;
        frame_valid <= !(has_par && !par_ok) && !stop_bad_q;
      end
    end
  end

  // R10: the result strobe lasts one cycle
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
  // R5: an idle falling edge always opens a frame
  p_edge_opens_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && fall) |=> st == ST_START);
  // R5: a start error reports nothing else
  p_start_err_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && start_err) |-> (!frame_valid && frame_data == '0 && !parity_err && !stop_err));
  // R1: no data bit above the selected length
  p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (frame_data >> nbits) == '0);
  // R6: a bad stop bit always invalidates the frame
  p_stop_invalid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && stop_err) |-> !frame_valid);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_rx_pkg::*;
#(
  parameter int DATA_MIN    = 5,
  parameter int DATA_MAX    = 9,
  parameter int CPB_W       = 16,
  parameter int PCT_W       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(DATA_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rxd,
  input  logic                invert,
  input  logic                msb_first,
  input  logic [CNT_W-1:0]    data_bits,
  input  logic [2:0]          parity_mode,
  input  logic [1:0]          stop_bits,
  input  logic [PCT_W-1:0]    sample_pct,
  input  logic [CPB_W-1:0]    clks_per_bit,
  output logic                frame_done,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                start_err,
  output logic                parity_err,
  output logic                stop_err,
  output logic                frame_valid
);
  logic             line, run, sample_tick, bit_end;
  logic [CNT_W-1:0] nbits;
  logic [1:0]       nstop;
  par_mode_e        pmode;

  always_comb begin
    if (data_bits < CNT_W'(DATA_MIN))      nbits = CNT_W'(DATA_MIN);
    else if (data_bits > CNT_W'(DATA_MAX)) nbits = CNT_W'(DATA_MAX);
    else                                   nbits = data_bits;
    nstop = (stop_bits == 2'd3) ? 2'd2 : stop_bits;
    pmode = (parity_mode > 3'd5) ? PAR_NONE : par_mode_e'(parity_mode);
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(rxd), .invert(invert), .line(line));

  rx_bit_timer #(.CPB_W(CPB_W), .PCT_W(PCT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .cpb(clks_per_bit), .pct(sample_pct),
    .sample_tick(sample_tick), .bit_end(bit_end));

  rx_frame_fsm #(.DATA_MAX(DATA_MAX), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line(line), .sample_tick(sample_tick),
    .bit_end(bit_end), .nbits(nbits), .pmode(pmode), .nstop(nstop),
    .msb_first(msb_first), .run(run), .frame_done(frame_done),
    .frame_data(frame_data), .start_err(start_err), .parity_err(parity_err),
    .stop_err(stop_err), .frame_valid(frame_valid));
endmodule

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;
  logic        clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic        inv = 1'b0, msb = 1'b0;
  logic [3:0]  dbits = 4'd8;
  logic [2:0]  pmode = 3'd0;
  logic [1:0]  sbits = 2'd1;
  logic [6:0]  pct = 7'd50;
  logic [15:0] cpb = 16'd16;
  logic        done, se, pe, fe, fv;
  logic [8:0]  dout;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  typedef struct {
    logic [8:0] d; logic s; logic p; logic f; logic v; string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  uart_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .invert(inv), .msb_first(msb),
    .data_bits(dbits), .parity_mode(pmode), .stop_bits(sbits), .sample_pct(pct),
    .clks_per_bit(cpb), .frame_done(done), .frame_data(dout), .start_err(se),
    .parity_err(pe), .stop_err(fe), .frame_valid(fv));

  // Monitor: pop the expected result on each strobe and compare
  always @(negedge clk) begin
    if (rst_n && done) begin
      nchk++;
      if (q.size() == 0) begin
        nfail++;
        $display("FAIL R10 unexpected strobe: got data=%h s/p/f/v=%b%b%b%b, expected none",
                 dout, se, pe, fe, fv);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (dout !== e.d || se !== e.s || pe !== e.p || fe !== e.f || fv !== e.v) begin
          nfail++;
          $display("FAIL %s: got data=%h s/p/f/v=%b%b%b%b, expected data=%h s/p/f/v=%b%b%b%b",
                   e.tag, dout, se, pe, fe, fv, e.d, e.s, e.p, e.f, e.v);
        end
      end
    end
  end

  function automatic int eff_bits();
    if (dbits < 5) return 5;
    if (dbits > 9) return 9;
    return int'(dbits);
  endfunction

  function automatic int eff_off();
    int p;
    p = (pct >= 1 && pct <= 99) ? int'(pct) : 50;
    return ((int'(cpb) - 1) * p) / 100;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = 1'b1 ^ inv;
    end
  endtask

  task automatic send_frame(input logic [8:0] val, input bit bad_par, input bit bad_stop,
                            input bit narrow, input string tag);
    int nb, ns, off, n;
    logic seq[16];
    logic [8:0] mv;
    logic pb;
    bit has_par;
    exp_t e;
    nb  = eff_bits();
    ns  = (sbits == 2'd3) ? 2 : int'(sbits);
    off = eff_off();
    mv  = val & 9'((1 << nb) - 1);
    seq[0] = 1'b0;
    for (int i = 0; i < nb; i++) seq[1 + i] = msb ? mv[nb - 1 - i] : mv[i];
    n = 1 + nb;
    has_par = (pmode >= 3'd1 && pmode <= 3'd5);
    if (has_par) begin
      case (pmode)
        3'd1: pb = ~(^mv);
        3'd2: pb = ^mv;
        3'd3: pb = 1'b0;
        3'd4: pb = 1'b1;
        default: pb = ^mv;
      endcase
      if (bad_par) pb = ~pb;
      seq[n] = pb; n++;
    end
    for (int i = 0; i < ns; i++) begin
      seq[n] = (bad_stop && i == 0) ? 1'b0 : 1'b1; n++;
    end
    e.d = mv; e.s = 1'b0;
    e.p = bad_par && (pmode >= 3'd1 && pmode <= 3'd4);
    e.f = bad_stop && (ns > 0);
    e.v = !e.p && !e.f;
    e.tag = tag;
    q.push_back(e);
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < int'(cpb); j++) begin
        logic v;
        v = seq[k];
        if (narrow && k >= 1 && k <= nb && j != off + 1) v = ~v;
        @(negedge clk); rxd = v ^ inv;
      end
    end
    idle(10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got no completion, expected all frames within limit");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9: reset state of every output
    nchk++;
    if (done !== 0 || dout !== 0 || se !== 0 || pe !== 0 || fe !== 0 || fv !== 0) begin
      nfail++;
      $display("FAIL R9 reset: got done=%b data=%h flags=%b%b%b%b, expected all zero",
               done, dout, se, pe, fe, fv);
    end
    idle(6);

    // R2 R10: plain 8-bit LSB-first frames
    send_frame(9'h0A5, 0, 0, 0, "R2 lsb 0xA5");
    send_frame(9'h03C, 0, 0, 0, "R10 0x3C");
    send_frame(9'h0FF, 0, 0, 0, "R10 0xFF");
    send_frame(9'h000, 0, 0, 0, "R10 0x00");
    msb = 1'b1;
    send_frame(9'h01E, 0, 0, 0, "R2 msb 0x1E");
    dbits = 4'd5;
    send_frame(9'h003, 0, 0, 0, "R2 msb 5b");
    msb = 1'b0;

    // R1: lengths and clamping
    send_frame(9'h015, 0, 0, 0, "R1 5 bits");
    dbits = 4'd9;
    send_frame(9'h1A5, 0, 0, 0, "R1 9 bits");
    dbits = 4'd12;
    send_frame(9'h155, 0, 0, 0, "R1 clamp high");
    dbits = 4'd3;
    send_frame(9'h00B, 0, 0, 0, "R1 clamp low");
    dbits = 4'd8;

    // R3: parity modes
    pmode = 3'd1;
    send_frame(9'h0A7, 0, 0, 0, "R3 odd good");
    send_frame(9'h0A7, 1, 0, 0, "R3 odd bad");
    pmode = 3'd2;
    send_frame(9'h031, 0, 0, 0, "R3 even good");
    send_frame(9'h031, 1, 0, 0, "R3 even bad");
    pmode = 3'd3;
    send_frame(9'h055, 1, 0, 0, "R3 zero bad");
    pmode = 3'd4;
    send_frame(9'h055, 0, 0, 0, "R3 one good");
    pmode = 3'd5;
    send_frame(9'h0C3, 1, 0, 0, "R3 ignore");
    pmode = 3'd7;
    send_frame(9'h012, 0, 0, 0, "R3 code7 as none");

    // R6 R7: stop bit counts
    pmode = 3'd2; sbits = 2'd2;
    send_frame(9'h06D, 0, 1, 0, "R6 two stops bad");
    sbits = 2'd3;
    send_frame(9'h06D, 0, 0, 0, "R6 code3 as two");
    sbits = 2'd0;
    send_frame(9'h0E1, 0, 0, 0, "R7 no stop");
    pmode = 3'd0;
    send_frame(9'h04E, 0, 0, 0, "R7 no stop no parity");
    sbits = 2'd1;
    send_frame(9'h081, 0, 1, 0, "R6 one stop bad");

    // R5: start glitch, then a normal frame
    begin
      exp_t e;
      e.d = 9'h000; e.s = 1'b1; e.p = 1'b0; e.f = 1'b0; e.v = 1'b0; e.tag = "R5 start error";
      q.push_back(e);
      for (int i = 0; i < 3; i++) begin @(negedge clk); rxd = 1'b0; end
      idle(2 * int'(cpb));
    end
    send_frame(9'h05A, 0, 0, 0, "R5 recover");

    // R4 R9: one-cycle data windows at the computed sample point
    send_frame(9'h0B4, 0, 0, 1, "R4 p50");
    pct = 7'd10;
    send_frame(9'h02D, 0, 0, 1, "R4 p10");
    pct = 7'd0;
    send_frame(9'h0C6, 0, 0, 1, "R4 p0 as 50");
    cpb = 16'd20; pct = 7'd99;
    send_frame(9'h079, 0, 0, 1, "R4 p99 c20");
    pct = 7'd25;
    send_frame(9'h0E8, 0, 0, 1, "R4 p25 c20");
    cpb = 16'd16; pct = 7'd50;

    // R8: inverted line
    @(negedge clk); inv = 1'b1; rxd = 1'b0;
    idle(8);
    send_frame(9'h0A5, 0, 0, 0, "R8 inverted 0xA5");
    send_frame(9'h00F, 0, 1, 0, "R8 inverted bad stop");
    @(negedge clk); inv = 1'b0; rxd = 1'b1;
    idle(8);

    repeat (40) @(negedge clk);
    nchk++;
    if (q.size() != 0) begin
      nfail++;
      $display("FAIL R10 missing strobes: got %0d pending, expected 0", q.size());
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule